// File: doc/BRIEF.md
# Gated Muxed Two-Stage Tick Divider

This block derives a slow output rate from one of four tick inputs, all of which are single-cycle strobes in the one system clock domain. Software configures it through a single 32-bit control word that is written whole and read back whole. The word picks the source line, an integer ratio from 1 to 16, an optional extra halving stage that follows the integer stage, and two gate bits. The output runs only when both gate bits are set. Software changes one field at a time by reading the word, editing the field and writing the word back, so every other bit keeps its value.

The selected ticks are counted by an integer stage. Its wrap strobe then passes through the halving stage, or bypasses it. At the end of each output period the block emits a one-cycle tick. It also drives a level output that is high for about the first half of each period, counted in source ticks. A new source, ratio or halving setting takes effect only at a period boundary. While the gate is off the counters are held cleared, so every enable starts a fresh period.

Top module: `tick_clk_divider`

## Requirements
- R1: After reset, rd_data is 0, enabled is 0, and out_tick and out_sq are 0. This is gated off, source 0, ratio 1, no halving.
- R2: rd_data always equals the last word written with wr_en high, in all 32 bits, and changes only on a write.
- R3: The output runs only while bit 31 and bit 15 of the word are both 1. With either bit 0, out_tick and out_sq stay 0 and source ticks are not counted.
- R4: enabled is 1 exactly when bit 31 or bit 15 of the word is 1.
- R5: Bits 25:24 hold a value s that selects src_tick[s]. Ticks on the other three lines have no effect on the outputs.
- R6: Bits 3:0 hold D, and the integer ratio is N = D+1. With halving off, out_tick is high for one cycle, in the cycle after the clock edge that samples every N-th selected tick of the period.
- R7: When bit 11 is 1, the period is 2N selected ticks instead of N.
- R8: Let p be the number of selected ticks counted so far in the current period. Without halving, out_sq is 1 while p < ceil(N/2). With halving, out_sq is 1 while p < N. out_sq is 0 while not running.
- R9: While the gate is off the period position is held at 0. A tick sampled in the cycle right after the enabling write is not counted. Ticks from the following cycle on are counted from the start of a fresh period.
- R10: A change to the select, ratio or halving field made while running takes effect from the next period boundary. The current period completes with the old setting.
- R11: Bits of the word other than 31, 25:24, 15, 11 and 3:0 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Current control word |
| src_tick | input | 4 | One tick strobe per source line |
| enabled | output | 1 | Either gate bit is set |
| out_tick | output | 1 | One-cycle strobe at each period end |
| out_sq | output | 1 | Roughly half-duty level at the output rate |

## Verification
The assertions assume reset starts low and that src_tick carries single-cycle strobes sampled by the system clock. An output tick is therefore always traceable to a source tick in the previous cycle. The stimulus drives ticks only at falling clock edges and changes the word only through whole-word writes that edit one field, mirroring software use. Tick patterns range from back-to-back strobes to spaced ones, and also place ticks on unselected lines and in the cycle just after an enable. A reference model in the bench, built on period position, predicts every output cycle.

// File: rtl/tick_clk_divider_pkg.sv
package tick_clk_divider_pkg;
   parameter int SEL_W = 2;
   parameter int DIV_W = 4;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic [DIV_W-1:0] div;
      logic             half;
   } tcd_cfg_t;
endpackage

// File: rtl/tcd_ctrl_reg.sv
module tcd_ctrl_reg
   import tick_clk_divider_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int SEL_LSB  = 24,
   parameter int DIV_LSB  = 0,
   parameter int HALF_POS = 11,
   parameter int GATE_HI  = 31,
   parameter int GATE_LO  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] word_q,
   output tcd_cfg_t         cfg,
   output logic             gate_all,
   output logic             gate_any
);
   always_ff @(posedge clk) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= wr_data;
   end

   assign cfg.sel  = word_q[SEL_LSB +: SEL_W];
   assign cfg.div  = word_q[DIV_LSB +: DIV_W];
   assign cfg.half = word_q[HALF_POS];
   assign gate_all = word_q[GATE_HI] & word_q[GATE_LO];
   assign gate_any = word_q[GATE_HI] | word_q[GATE_LO];
endmodule

// File: rtl/tcd_int_stage.sv
module tcd_int_stage #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   output logic [DIV_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = tick & (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (tick)     cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/tcd_half_stage.sv
module tcd_half_stage #(
   parameter int DIV_W   = 4,
   parameter bit HALF_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wrap_in,
   input  logic             half,
   input  logic [DIV_W-1:0] cnt,
   input  logic [DIV_W-1:0] div,
   output logic             final_o,
   output logic             sq_o
);
   logic first_half_int;
   assign first_half_int = (cnt <= (div >> 1));

   generate
      if (HALF_EN) begin : g_half
         logic phase;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)      phase <= 1'b0;
            else if (wrap_in && half) phase <= ~phase;
         end
         assign final_o = wrap_in & (~half | phase);
         assign sq_o    = half ? ~phase : first_half_int;
      end else begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = ^{clk, rst_n, clr, half};
         assign final_o = wrap_in;
         assign sq_o    = first_half_int;
      end
   endgenerate
endmodule

// File: rtl/tick_clk_divider.sv
module tick_clk_divider
   import tick_clk_divider_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int N_SRC    = 4,
   parameter int SEL_LSB  = 24,
   parameter int DIV_LSB  = 0,
   parameter int HALF_POS = 11,
   parameter int GATE_HI  = 31,
   parameter int GATE_LO  = 15,
   parameter bit HALF_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic [N_SRC-1:0] src_tick,
   output logic             enabled,
   output logic             out_tick,
   output logic             out_sq
);
   localparam int SRC_SPAN = 2 ** SEL_W;

   generate
      if (N_SRC != SRC_SPAN) begin : g_bad_src
         $error("N_SRC must equal 2**SEL_W");
      end
      if (SEL_LSB + SEL_W > REG_W || DIV_LSB + DIV_W > REG_W ||
          HALF_POS >= REG_W || GATE_HI >= REG_W || GATE_LO >= REG_W) begin : g_bad_pos
         $error("control field lies outside the word");
      end
      if (GATE_HI == GATE_LO) begin : g_bad_gate
         $error("gate bits must differ");
      end
   endgenerate

   tcd_cfg_t cfg_reg, cfg_act;
   logic     gate_on, run_q, active;
   logic     sel_tick, wrap, final_s, sq_s, tick_q;
   logic [DIV_W-1:0] cnt;

   tcd_ctrl_reg #(
      .REG_W(REG_W), .SEL_LSB(SEL_LSB), .DIV_LSB(DIV_LSB),
      .HALF_POS(HALF_POS), .GATE_HI(GATE_HI), .GATE_LO(GATE_LO)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .word_q(rd_data), .cfg(cfg_reg), .gate_all(gate_on), .gate_any(enabled)
   );

   // Active settings: follow the word while idle, reload at each period end
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cfg_act <= '0;
         tick_q  <= 1'b0;
      end else begin
         run_q  <= gate_on;
         tick_q <= final_s;
         if (!run_q || final_s) cfg_act <= cfg_reg;
      end
   end

   assign active   = run_q & gate_on;
   assign sel_tick = active & src_tick[cfg_act.sel];

   tcd_int_stage #(.DIV_W(DIV_W)) i_int (
      .clk(clk), .rst_n(rst_n), .clr(~active), .tick(sel_tick),
      .div(cfg_act.div), .cnt(cnt), .wrap(wrap)
   );

   tcd_half_stage #(.DIV_W(DIV_W), .HALF_EN(HALF_EN)) i_half (
      .clk(clk), .rst_n(rst_n), .clr(~active), .wrap_in(wrap),
      .half(cfg_act.half), .cnt(cnt), .div(cfg_act.div),
      .final_o(final_s), .sq_o(sq_s)
   );

   assign out_tick = tick_q & gate_on;
   assign out_sq   = active & sq_s;
endmodule

// File: rtl/tick_clk_divider_chk.sv
module tick_clk_divider_chk #(
   parameter int REG_W = 32,
   parameter int N_SRC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic [N_SRC-1:0] src_tick,
   input logic             out_tick,
   input logic             out_sq,
   input logic             gate_on
);
   a_r3_idle_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |-> (!out_tick && !out_sq));

   a_r9_no_tick_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |=> !out_tick);

   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data));

   a_r6_tick_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(|src_tick));
endmodule

bind tick_clk_divider tick_clk_divider_chk i_chk (.*);

// File: tb/test_tick_clk_divider.sv
module test_tick_clk_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  src_tick = '0;
   logic        enabled, out_tick, out_sq;

   always #10 clk = ~clk;

   tick_clk_divider i_tick_clk_divider (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_tick(src_tick), .enabled(enabled),
      .out_tick(out_tick), .out_sq(out_sq)
   );

   typedef struct {
      int        cyc;
      string     req;
      bit        tk;
      bit        sq;
      bit [31:0] rd;
      bit        en;
   } exp_t;

   exp_t q[$];
   int   cur = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 0;

   // software shadow and period model
   bit [31:0] r_reg = '0;
   bit        m_run = 0;
   int        a_sel = 0, a_n = 1, pos = 0;
   bit        a_h = 0;

   always @(posedge clk) cur <= cur + 1;

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pop expectations whose cycle has passed
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc < cur) begin
         exp_t e;
         e = q.pop_front();
         chk(e.req, "out_tick", out_tick, e.tk);
         chk(e.req, "out_sq", out_sq, e.sq);
         chk(e.req, "rd_data", rd_data, e.rd);
         chk(e.req, "enabled", enabled, e.en);
      end
   end

   function automatic bit gate_of(bit [31:0] w);
      return w[31] & w[15];
   endfunction

   function automatic bit sq_of(int p, int n, bit h);
      return h ? (p < n) : (p < (n + 1) / 2);
   endfunction

   task automatic load_cfg();
      a_sel = int'(r_reg[25:24]);
      a_n   = int'(r_reg[3:0]) + 1;
      a_h   = r_reg[11];
   endtask

   // driver: one cycle of stimulus, expectation pushed for the next cycle
   task automatic step(bit we, bit [31:0] wd, bit [3:0] tk, string req);
      bit   g, act, pulse, g2;
      exp_t e;
      wr_en    = we;
      wr_data  = wd;
      src_tick = tk;
      g     = gate_of(r_reg);
      act   = m_run & g;
      pulse = 0;
      if (act && tk[a_sel]) begin
         pos++;
         if (pos == a_n * (a_h ? 2 : 1)) begin
            pulse = 1;
            pos   = 0;
            load_cfg();
         end
      end
      if (!act) pos = 0;
      if (!m_run) load_cfg();
      m_run = g;
      if (we) r_reg = wd;
      g2 = gate_of(r_reg);
      e.cyc = cur;
      e.req = req;
      e.tk  = pulse & g2;
      e.sq  = m_run & g2 & sq_of(pos, a_n, a_h);
      e.rd  = r_reg;
      e.en  = r_reg[31] | r_reg[15];
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run_ticks(int n, int line, int gap, string req);
      for (int i = 0; i < n; i++) begin
         step(0, '0, 4'(1 << line), req);
         for (int j = 0; j < gap; j++) step(0, '0, 4'b0, req);
      end
   endtask

   task automatic set_rate(int d, bit h, string req);
      bit [31:0] v;
      v = r_reg;
      v[3:0] = 4'(d);
      v[11]  = h;
      step(1, v, 4'b0, req);
   endtask

   task automatic set_sel(int s, string req);
      bit [31:0] v;
      v = r_reg;
      v[25:24] = 2'(s);
      step(1, v, 4'b0, req);
   endtask

   task automatic set_gates(bit hi, bit lo, string req);
      bit [31:0] v;
      v = r_reg;
      v[31] = hi;
      v[15] = lo;
      step(1, v, 4'b0, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "rd_data", rd_data, 0);
      chk("R1", "enabled", enabled, 0);
      chk("R1", "out_tick", out_tick, 0);
      chk("R1", "out_sq", out_sq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "out_sq after release", out_sq, 0);

      // R2: full word readback including undefined bits
      step(1, 32'h4A5A_7AF0, 4'b0, "R2");
      step(0, '0, 4'b0, "R2");
      // R4 and R3: a single gate bit reports enabled but does not run
      set_gates(1, 0, "R4");
      run_ticks(4, 2, 0, "R3");
      set_gates(0, 1, "R4");
      run_ticks(4, 2, 1, "R3");
      set_gates(0, 0, "R4");

      // R6: ratio 3, no halving, source 0
      set_rate(2, 0, "R6");
      set_sel(0, "R5");
      set_gates(1, 1, "R9");
      step(0, '0, 4'b0, "R9");
      run_ticks(9, 0, 1, "R6");
      // R5: unselected lines ignored
      run_ticks(3, 1, 0, "R5");
      run_ticks(2, 3, 1, "R5");
      run_ticks(4, 0, 0, "R6");
      // R11: flipping undefined bits mid-run changes nothing
      step(1, r_reg ^ 32'h40F0_70F0, 4'b0, "R11");
      run_ticks(5, 0, 0, "R11");

      // R10: change ratio and halving mid-period
      run_ticks(1, 0, 0, "R10");
      set_rate(0, 1, "R10");
      set_sel(3, "R10");
      run_ticks(2, 0, 0, "R10");
      run_ticks(6, 3, 0, "R10");

      // R7, R8: ratio 4 with halving on source 3
      set_rate(3, 1, "R7");
      run_ticks(20, 3, 1, "R7");
      run_ticks(8, 3, 0, "R8");
      // R8: ratio 16 without halving
      set_rate(15, 0, "R8");
      run_ticks(40, 3, 0, "R8");
      // R8: ratio 5 odd split
      set_rate(4, 0, "R8");
      run_ticks(12, 3, 1, "R8");

      // R9: disable mid-period, reconfigure, restart fresh
      run_ticks(2, 3, 0, "R9");
      set_gates(0, 0, "R9");
      run_ticks(3, 3, 0, "R9");
      set_rate(2, 1, "R9");
      set_gates(1, 1, "R9");
      step(0, '0, 4'b1000, "R9");
      run_ticks(14, 3, 0, "R9");

      repeat (2) step(0, '0, 4'b0, "R6");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule